// File: doc/BRIEF.md
# ULPI Transceiver Low-Power Mode Controller

This block is the transceiver-side sequencer for the ULPI suspend state. Once the rest of the chip has decided to enter low power, the controller takes the bus with DIR held high and stops the output clock. While the transceiver clocks are stopped, it drives the 8-bit data bus straight from the full-speed single-ended receivers and from a sticky interrupt flag. That flag is raised by enabled rising or falling transitions on the four cable comparators: VBUS valid, session valid, session end and ID ground.

The link wakes the transceiver by raising STP. The controller then counts a start-up period in ticks of a free-running reference enable. After that it restarts the output clock, and one clock later it lowers DIR, which starts a single turnaround cycle. At that point it also sets the suspend-control bit back to 1. It then waits until STP is low before it settles in synchronous idle. If STP drops while DIR is still high, the wake is a false resume and the controller goes straight back to low power.

Top module: `ulpi_lpm_ctrl`

## Requirements
- R1: While rst_ni is low: dir_o=0, clk_run_o=1, suspendm_o=1 and data_o=0.
- R2: A high lpm_enter_i sampled in synchronous idle puts the block in low power from the next edge: dir_o=1, clk_run_o=0, suspendm_o=0.
- R3: In low power, data_o[0] follows dp_i and data_o[1] follows dm_i with no clock edge in between, so SE0 reads 2'b00 and SE1 reads 2'b11. Bits 2 and 7:4 read 0.
- R4: Comparator bit order on cmp_i is [0] VBUS valid, [1] session valid, [2] session end, [3] ID ground. In low power, a 0-to-1 change on bit k with rise_en_i[k]=1, or a 1-to-0 change with fall_en_i[k]=1, drives data_o[3] high from the next clock edge. A change whose direction is not enabled leaves data_o[3] low.
- R5: data_o[3] stays high until the exit completes, and it reads 0 on the next entry.
- R6: While quiet_i=1, changes on the VBUS-valid (bit 0) and session-end (bit 2) comparators raise no interrupt. Bits 1 and 3 still do.
- R7: After STP is seen high in low power, clk_run_o rises on the TSTART-th edge with tick_i high. Edges with tick_i low do not count, and dir_o stays high until then.
- R8: If stp_i is low at an edge while the block is still counting start-up or has restarted the clock with dir_o high, the block returns to low power from the next edge (clk_run_o=0, dir_o=1), and it stays there.
- R9: dir_o falls one edge after clk_run_o rises, and suspendm_o reads 1 in that same cycle.
- R10: After dir_o falls there is exactly one turnaround cycle. The block then holds dir_o low while stp_i is high, and with stp_i low it enters synchronous idle. Outside low power, data_o reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference enable that paces the start-up count |
| lpm_enter_i | input | 1 | Request to enter low power from synchronous idle |
| stp_i | input | 1 | STP from the link |
| dp_i | input | 1 | D+ single-ended receiver |
| dm_i | input | 1 | D- single-ended receiver |
| cmp_i | input | 4 | Comparators: VBUS valid, session valid, session end, ID ground |
| rise_en_i | input | 4 | Per-comparator rising-edge interrupt enable |
| fall_en_i | input | 4 | Per-comparator falling-edge interrupt enable |
| quiet_i | input | 1 | Mask for VBUS-valid and session-end interrupts in low power |
| dir_o | output | 1 | Bus direction, high while the transceiver owns the bus |
| data_o | output | 8 | Data bus value driven by the transceiver |
| clk_run_o | output | 1 | Output clock enable |
| suspendm_o | output | 1 | Suspend-control bit (1 = not suspended) |

## Verification
The line-state bits respond in the same cycle their inputs change, so those checks are made in the same half-cycle as the stimulus. The interrupt bit is due one edge after a comparator change, which is why the bench first checks it low in the stimulus cycle and then high in the next one. clk_run_o is due on the TSTART-th ticking edge after STP is taken, dir_o and suspendm_o one edge after that, and a false resume shows one edge after STP drops. The driver pushes each expectation just after a falling edge, once the inputs for that cycle are set. The monitor compares all outputs two nanoseconds later, well before the next rising edge.

// File: rtl/ulpi_lpm_pkg.sv
package ulpi_lpm_pkg;
  typedef enum logic [2:0] {
    ST_SYNC,
    ST_LPM,
    ST_START,
    ST_CLKON,
    ST_TURN,
    ST_HOLD
  } lpm_state_e;

  localparam int NUM_CMP  = 4;
  localparam int CMP_VBUS = 0;
  localparam int CMP_SESS = 1;
  localparam int CMP_SEND = 2;
  localparam int CMP_ID   = 3;

  localparam int BUS_W   = 8;
  localparam int BIT_DP  = 0;
  localparam int BIT_DM  = 1;
  localparam int BIT_IRQ = 3;
endpackage

// File: rtl/ulpi_lpm_cmp.sv
module ulpi_lpm_cmp #(
  parameter int          N          = 4,
  parameter logic [N-1:0] QUIET_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         clr_i,
  input  logic         quiet_i,
  input  logic [N-1:0] cmp_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  output logic         irq_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] hit;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cmp_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_edge
    logic rise, fall, gate;
    assign rise   = cmp_i[k] & ~prev_q[k] & rise_en_i[k];
    assign fall   = ~cmp_i[k] & prev_q[k] & fall_en_i[k];
    assign gate   = ~(quiet_i & QUIET_MASK[k]);
    assign hit[k] = (rise | fall) & gate;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (clr_i)            irq_q <= 1'b0;
    else if (arm_i && |hit)    irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q); // R5
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !arm_i) |=> !irq_q); // R4
endmodule

// File: rtl/ulpi_lpm_timer.sv
module ulpi_lpm_timer #(
  parameter int TSTART = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(TSTART + 1);
  localparam logic [CW-1:0] LAST = CW'(TSTART - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  AST_TIMER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/ulpi_lpm_fsm.sv
module ulpi_lpm_fsm
  import ulpi_lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_i,
  input  logic       stp_i,
  input  logic       done_i,
  output lpm_state_e state_o,
  output logic       suspendm_o
);
  lpm_state_e state_q, state_d;
  logic       susp_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SYNC:  if (enter_i) state_d = ST_LPM;
      ST_LPM:   if (stp_i)   state_d = ST_START;
      ST_START: begin
        if (!stp_i)      state_d = ST_LPM;
        else if (done_i) state_d = ST_CLKON;
      end
      ST_CLKON: state_d = stp_i ? ST_TURN : ST_LPM;
      ST_TURN:  state_d = stp_i ? ST_HOLD : ST_SYNC;
      ST_HOLD:  if (!stp_i)  state_d = ST_SYNC;
      default:  state_d = ST_SYNC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SYNC;
    else         state_q <= state_d;
  end

  // suspend bit: cleared on entry, set when the bus is handed back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              susp_q <= 1'b1;
    else if (state_q == ST_SYNC && enter_i)   susp_q <= 1'b0;
    else if (state_q == ST_CLKON && stp_i)    susp_q <= 1'b1;
  end

  assign state_o    = state_q;
  assign suspendm_o = susp_q;

  AST_FALSE_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_START || state_q == ST_CLKON) && !stp_i) |=> state_q == ST_LPM); // R8
  AST_ONE_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |=> state_q != ST_TURN); // R10
  AST_HOLD_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && stp_i) |=> state_q == ST_HOLD); // R10
endmodule

// File: rtl/ulpi_lpm_ctrl.sv
module ulpi_lpm_ctrl
  import ulpi_lpm_pkg::*;
#(
  parameter int TSTART = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               lpm_enter_i,
  input  logic               stp_i,
  input  logic               dp_i,
  input  logic               dm_i,
  input  logic [NUM_CMP-1:0] cmp_i,
  input  logic [NUM_CMP-1:0] rise_en_i,
  input  logic [NUM_CMP-1:0] fall_en_i,
  input  logic               quiet_i,
  output logic               dir_o,
  output logic [BUS_W-1:0]   data_o,
  output logic               clk_run_o,
  output logic               suspendm_o
);
  localparam logic [NUM_CMP-1:0] QUIET_MASK =
    NUM_CMP'((1 << CMP_VBUS) | (1 << CMP_SEND));

  lpm_state_e state;
  logic       lp_active, done, irq;

  assign lp_active = (state == ST_LPM) || (state == ST_START) || (state == ST_CLKON);

  ulpi_lpm_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (lpm_enter_i),
    .stp_i      (stp_i),
    .done_i     (done),
    .state_o    (state),
    .suspendm_o (suspendm_o)
  );

  ulpi_lpm_timer #(.TSTART(TSTART)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_START),
    .tick_i (tick_i),
    .done_o (done)
  );

  ulpi_lpm_cmp #(.N(NUM_CMP), .QUIET_MASK(QUIET_MASK)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (lp_active),
    .clr_i     (!lp_active),
    .quiet_i   (quiet_i),
    .cmp_i     (cmp_i),
    .rise_en_i (rise_en_i),
    .fall_en_i (fall_en_i),
    .irq_o     (irq)
  );

  // bus is driven combinationally while clocks are stopped
  always_comb begin
    data_o = '0;
    if (lp_active) begin
      data_o[BIT_DP]  = dp_i;
      data_o[BIT_DM]  = dm_i;
      data_o[BIT_IRQ] = irq;
    end
  end

  assign dir_o     = lp_active;
  assign clk_run_o = !((state == ST_LPM) || (state == ST_START));

  AST_DIR_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_o) |-> $past(clk_run_o)); // R9
  AST_SUSPEND_ON_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_o) |-> suspendm_o); // R9
  AST_CLK_BEFORE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_run_o) |-> (dir_o || $past(!dir_o))); // R7
  AST_IDLE_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_o |-> (data_o == '0)); // R10
endmodule

// File: tb/ulpi_lpm_ctrl_test.sv
`timescale 1ns/100ps
module ulpi_lpm_ctrl_test;
  localparam int T = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1, enter = 1'b0, stp = 1'b0, dp = 1'b0, dm = 1'b0, quiet = 1'b0;
  logic [3:0] cmp = '0, rise_en = '0, fall_en = '0;
  logic dir, run, susp;
  logic [7:0] data;

  always #4 clk = ~clk;

  ulpi_lpm_ctrl #(.TSTART(T)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .lpm_enter_i(enter), .stp_i(stp),
    .dp_i(dp), .dm_i(dm), .cmp_i(cmp), .rise_en_i(rise_en), .fall_en_i(fall_en),
    .quiet_i(quiet), .dir_o(dir), .data_o(data), .clk_run_o(run), .suspendm_o(susp)
  );

  typedef struct {
    string      tag;
    logic       dir, run, susp;
    logic [7:0] data;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit fin = 0;
  logic m_lp = 0, m_run = 1, m_susp = 1, m_irq = 0;

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag);
    exp_t e;
    e.tag  = tag;
    e.dir  = m_lp;
    e.run  = m_run;
    e.susp = m_susp;
    e.data = m_lp ? {4'b0, m_irq, 1'b0, dm, dp} : 8'h00;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (dir !== e.dir || run !== e.run || susp !== e.susp || data !== e.data) begin
          n_bad++;
          $display("FAIL %s: got dir=%b run=%b susp=%b data=%h, exp dir=%b run=%b susp=%b data=%h",
                   e.tag, dir, run, susp, data, e.dir, e.run, e.susp, e.data);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(); chk("R1 reset state");
    rst_ni = 1'b1;
    step(); dp = 1; dm = 0; chk("R10 idle bus zero");
    rise_en = 4'b0010; fall_en = 4'b0000;
    enter = 1;
    step(); enter = 0; dp = 0; dm = 0;
    m_lp = 1; m_run = 0; m_susp = 0; chk("R2 entry / R3 SE0");
    step(); dp = 1; dm = 0; chk("R3 dp only");
    step(); dp = 0; dm = 1; chk("R3 dm only");
    step(); dp = 1; dm = 1; chk("R3 SE1");
    // R4: disabled rising on ID ground
    step(); cmp[3] = 1; chk("R4 no irq same cycle");
    step(); chk("R4 disabled rising ignored");
    // R4: enabled rising on session valid
    cmp[1] = 1; chk("R4 not before edge");
    step(); m_irq = 1; chk("R4 enabled rising");
    cmp[1] = 0;
    step(); step(); chk("R5 irq sticky");
    // R7: exit with stalled ticks
    stp = 1; tick = 0;
    step();
    repeat (10) step();
    chk("R7 no count without tick");
    tick = 1;
    repeat (T - 1) step();
    chk("R7 clock still off");
    step(); m_run = 1; chk("R7 clock restarts dir high");
    step(); m_lp = 0; m_susp = 1; m_irq = 0; chk("R9 dir low suspendm set");
    step(); chk("R10 hold while stp high");
    stp = 0;
    step(); chk("R10 sync idle");
    dp = 0; dm = 1;
    step(); chk("R10 idle ignores line");
    // second session: quiet masking and falling edge
    quiet = 1; rise_en = 4'b1111; fall_en = 4'b1000;
    enter = 1;
    step(); enter = 0; m_lp = 1; m_run = 0; m_susp = 0; chk("R5 irq cleared on entry");
    cmp[0] = 1;
    step(); step(); chk("R6 VBUS valid masked");
    cmp[2] = 1;
    step(); step(); chk("R6 session end masked");
    cmp[3] = 0;
    step(); m_irq = 1; chk("R4 enabled falling");
    // R8: false resume during start-up count
    stp = 1;
    step();
    repeat (4) step(); chk("R8 counting");
    stp = 0;
    step(); chk("R8 back in low power");
    repeat (T + 5) step(); chk("R8 stays in low power");
    // R8: false resume after clock restart
    stp = 1;
    step();
    repeat (T) step(); m_run = 1; chk("R8 clock on before drop");
    stp = 0;
    step(); m_run = 0; chk("R8 false resume after restart");
    step(); chk("R8 remains");
    #5;
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule